// File: doc/BRIEF.md
# Soft-Start and Overcurrent Hiccup Controller

This block holds a digital soft-start level that stands in for the voltage on an external soft-start capacitor in a voltage-mode PWM power stage. After reset, or after any shutdown, the level climbs by a fixed step on every microsecond tick up to a ceiling. While it climbs, the PWM duty is held down by the level, and only the per-pulse current limit outside this block protects the switches. Once the level passes the error command, soft-start is over and the delayed overcurrent shutdown becomes active.

An overcurrent indication after soft-start stops the charging and lets the level sag slowly. It also loads a retriggerable hold-off timer. If the timer runs out before the level sags to the shutdown threshold, charging resumes. If the level reaches the threshold first, the outputs are turned off and fault is driven high. The level then keeps draining slowly until it hits a low reset level, and a fresh soft-start begins, which gives a hiccup restart. A short-circuit request jumps straight into that hiccup. Hard faults (reference low, input undervoltage, over-temperature) turn the outputs off at once and drain the level quickly. Restart waits until the fault has cleared and the level is at or below the reset level.

The fault indication is three-state, made of a drive value and a drive enable. It floats during a fault-free soft-start. Otherwise it is driven high exactly when the outputs are off.

Top module: `ss_hiccup_ctrl`

## Requirements
- R1: On each tick during soft-start, and after it while no overcurrent or short circuit is seen, the level rises by CHG_STEP and saturates at CLAMP_LVL. It never exceeds CLAMP_LVL.
- R2: `ss_done` rises on the clock edge after the level is strictly greater than `err_cmd`. A level equal to `err_cmd` keeps soft-start running.
- R3: During soft-start, `oc_flag` has no effect: the level keeps rising, the outputs stay enabled and `ss_done` stays low.
- R4: After soft-start, an `oc_flag` of 1 stops charging. The level holds for the cycle that detects it and then drops by SLOW_STEP per tick. The outputs stay enabled and `ss_done` stays high.
- R5: The hold-off timer reloads to HOLD_TICKS on every cycle with `oc_flag` = 1 and counts down one per tick. When it reaches zero with `oc_flag` low and the level above SAG_LVL, charging resumes.
- R6: While the hold-off is pending, a level at or below SAG_LVL causes shutdown. `out_en` goes to 0, `ss_done` to 0, and fault is driven high.
- R7: In shutdown the level drops by SLOW_STEP per tick and never rises. On the edge after it is at or below RESET_LVL, soft-start restarts with the outputs enabled.
- R8: Any bit of `hard_flt` at 1 drives `out_en` to 0 and fault high in the same cycle. The level then drops by FAST_STEP per tick, floored at 0.
- R9: After a hard fault, soft-start restarts only once all `hard_flt` bits are 0 and the level is at or below RESET_LVL. A level at 0 with a fault still present keeps the outputs off.
- R10: `fault_oe` is 0 during soft-start when no hard fault is present. In every other case `fault_oe` is 1 and `fault_val` equals the inverse of `out_en`.
- R11: `sc_req` = 1 in any state with enabled outputs moves the block into shutdown on the next edge, with the level held that cycle. From there it follows the hiccup of R7.
- R12: After reset the level is 0, soft-start is running, `ss_done` is 0, `out_en` is 1 and `fault_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond; paces level steps and the hold-off timer |
| oc_flag | input | 1 | Overcurrent seen by the current comparator |
| sc_req | input | 1 | Short-circuit shutdown request |
| hard_flt | input | NFLT | Hard-fault flags, one per source; any 1 is a fault |
| err_cmd | input | LVL_W | Error command level that soft-start must exceed |
| ss_level | output | LVL_W | Soft-start level, limits the PWM duty |
| ss_done | output | 1 | Soft-start finished, overcurrent shutdown armed |
| out_en | output | 1 | Enable for the gate outputs |
| fault_val | output | 1 | Value driven on the fault line |
| fault_oe | output | 1 | Drive enable of the fault line (0 = high impedance) |

## Verification
The hardest condition to reach is recovery before shutdown. This needs an overcurrent burst long enough to sag the level, yet short enough that the hold-off timer expires with the level still above the sag threshold. It then has to be told apart from a timer that is still counting. The stimulus table holds the overcurrent for a few ticks, releases it, and samples one tick before the expected expiry, when the level is still sagging. It then samples again after expiry, when the level must have climbed back to the ceiling. A later row holds the overcurrent long enough to cross the threshold, so the same path is also seen ending in shutdown, followed by the slow drain to the reset level.

// File: rtl/ss_hiccup_pkg.sv
package ss_hiccup_pkg;
   typedef enum logic [2:0] {
      SS_RAMP   = 3'd0,
      SS_RUN    = 3'd1,
      SS_OCHOLD = 3'd2,
      SS_SHUT   = 3'd3,
      SS_HARD   = 3'd4
   } ss_state_e;

   typedef enum logic [1:0] {
      LV_HOLD   = 2'd0,
      LV_CHARGE = 2'd1,
      LV_SLOW   = 2'd2,
      LV_FAST   = 2'd3
   } lv_mode_e;
endpackage

// File: rtl/ss_level_acc.sv
module ss_level_acc
   import ss_hiccup_pkg::*;
#(
   parameter int LVL_W     = 10,
   parameter int CLAMP_LVL = 900,
   parameter int CHG_STEP  = 2,
   parameter int SLOW_STEP = 1,
   parameter int FAST_STEP = 300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  lv_mode_e         mode,
   output logic [LVL_W-1:0] lvl
);
   localparam int SW = LVL_W + 1;

   logic [SW-1:0]    sum;
   logic [LVL_W-1:0] chg_lvl;
   logic [LVL_W-1:0] slow_lvl;
   logic [LVL_W-1:0] fast_lvl;
   logic [LVL_W-1:0] nxt;

   assign sum      = {1'b0, lvl} + SW'(CHG_STEP);
   assign chg_lvl  = (sum > SW'(CLAMP_LVL)) ? LVL_W'(CLAMP_LVL) : sum[LVL_W-1:0];
   assign slow_lvl = (lvl < LVL_W'(SLOW_STEP)) ? '0 : lvl - LVL_W'(SLOW_STEP);

   generate
      if (FAST_STEP >= CLAMP_LVL) begin : g_fast_clear
         assign fast_lvl = '0;
      end else begin : g_fast_sub
         assign fast_lvl = (lvl < LVL_W'(FAST_STEP)) ? '0 : lvl - LVL_W'(FAST_STEP);
      end
   endgenerate

   always_comb begin
      unique case (mode)
         LV_CHARGE: nxt = chg_lvl;
         LV_SLOW:   nxt = slow_lvl;
         LV_FAST:   nxt = fast_lvl;
         default:   nxt = lvl;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lvl <= '0;
      else if (tick) lvl <= nxt;
   end
endmodule

// File: rtl/ss_hold_timer.sv
module ss_hold_timer #(
   parameter int HOLD_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(HOLD_TICKS + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (trig)                   cnt <= CW'(HOLD_TICKS);
      else if (tick && (cnt != '0))    cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/ss_seq.sv
module ss_seq
   import ss_hiccup_pkg::*;
#(
   parameter int LVL_W     = 10,
   parameter int SAG_LVL   = 850,
   parameter int RESET_LVL = 54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hard_any,
   input  logic             oc_flag,
   input  logic             sc_req,
   input  logic             hold_act,
   input  logic [LVL_W-1:0] lvl,
   input  logic [LVL_W-1:0] err_cmd,
   output ss_state_e        st,
   output lv_mode_e         mode
);
   ss_state_e nst;
   logic      at_sag;
   logic      at_reset;

   assign at_sag   = (lvl <= LVL_W'(SAG_LVL));
   assign at_reset = (lvl <= LVL_W'(RESET_LVL));

   always_comb begin
      nst = st;
      if (hard_any) begin
         nst = SS_HARD;
      end else begin
         unique case (st)
            SS_RAMP:   if (sc_req) nst = SS_SHUT;
                       else if (lvl > err_cmd) nst = SS_RUN;
            SS_RUN:    if (sc_req) nst = SS_SHUT;
                       else if (oc_flag) nst = SS_OCHOLD;
            SS_OCHOLD: if (sc_req || at_sag) nst = SS_SHUT;
                       else if (!hold_act && !oc_flag) nst = SS_RUN;
            SS_SHUT:   if (at_reset) nst = SS_RAMP;
            SS_HARD:   if (at_reset) nst = SS_RAMP;
            default:   nst = SS_HARD;
         endcase
      end
   end

   always_comb begin
      if (hard_any) begin
         mode = LV_FAST;
      end else begin
         unique case (st)
            SS_RAMP:   mode = sc_req ? LV_HOLD : LV_CHARGE;
            SS_RUN:    mode = (sc_req || oc_flag) ? LV_HOLD : LV_CHARGE;
            SS_OCHOLD: mode = LV_SLOW;
            SS_SHUT:   mode = LV_SLOW;
            default:   mode = LV_FAST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SS_RAMP;
      else        st <= nst;
   end
endmodule

// File: rtl/ss_hiccup_ctrl.sv
module ss_hiccup_ctrl
   import ss_hiccup_pkg::*;
#(
   parameter int LVL_W      = 10,
   parameter int CLAMP_LVL  = 900,
   parameter int SAG_LVL    = 850,
   parameter int RESET_LVL  = 54,
   parameter int CHG_STEP   = 2,
   parameter int SLOW_STEP  = 1,
   parameter int FAST_STEP  = 300,
   parameter int HOLD_TICKS = 50,
   parameter int NFLT       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             oc_flag,
   input  logic             sc_req,
   input  logic [NFLT-1:0]  hard_flt,
   input  logic [LVL_W-1:0] err_cmd,
   output logic [LVL_W-1:0] ss_level,
   output logic             ss_done,
   output logic             out_en,
   output logic             fault_val,
   output logic             fault_oe
);
   generate
      if (CLAMP_LVL >= (1 << LVL_W)) begin : g_bad_clamp
         $error("CLAMP_LVL does not fit in LVL_W bits");
      end
      if (!(RESET_LVL < SAG_LVL && SAG_LVL < CLAMP_LVL)) begin : g_bad_order
         $error("levels must satisfy RESET_LVL < SAG_LVL < CLAMP_LVL");
      end
      if (CHG_STEP < 1 || SLOW_STEP < 1 || FAST_STEP < 1 || HOLD_TICKS < 1) begin : g_bad_step
         $error("steps and hold count must be positive");
      end
   endgenerate

   ss_state_e st;
   lv_mode_e  mode;
   logic      hard_any;
   logic      hold_act;
   logic      st_on;

   assign hard_any = |hard_flt;

   ss_level_acc #(
      .LVL_W(LVL_W), .CLAMP_LVL(CLAMP_LVL), .CHG_STEP(CHG_STEP),
      .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .tick(tick_us), .mode(mode), .lvl(ss_level)
   );

   ss_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk(clk), .rst_n(rst_n), .tick(tick_us), .trig(oc_flag), .active(hold_act)
   );

   ss_seq #(.LVL_W(LVL_W), .SAG_LVL(SAG_LVL), .RESET_LVL(RESET_LVL)) u_seq (
      .clk(clk), .rst_n(rst_n), .hard_any(hard_any), .oc_flag(oc_flag),
      .sc_req(sc_req), .hold_act(hold_act), .lvl(ss_level), .err_cmd(err_cmd),
      .st(st), .mode(mode)
   );

   assign st_on     = (st == SS_RAMP) || (st == SS_RUN) || (st == SS_OCHOLD);
   assign out_en    = st_on && !hard_any;
   assign ss_done   = (st == SS_RUN) || (st == SS_OCHOLD);
   assign fault_oe  = (st != SS_RAMP) || hard_any;
   assign fault_val = !out_en;
endmodule

// File: rtl/ss_hiccup_chk.sv
module ss_hiccup_chk #(
   parameter int LVL_W     = 10,
   parameter int CLAMP_LVL = 900,
   parameter int NFLT      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sc_req,
   input logic [NFLT-1:0]  hard_flt,
   input logic [LVL_W-1:0] err_cmd,
   input logic [LVL_W-1:0] ss_level,
   input logic             ss_done,
   input logic             out_en,
   input logic             fault_val,
   input logic             fault_oe
);
   AST_LEVEL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      ss_level <= LVL_W'(CLAMP_LVL)); // R1

   AST_DONE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_done) |-> ($past(ss_level) > $past(err_cmd))); // R2

   AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en && $past(!out_en)) |-> (ss_level <= $past(ss_level))); // R7

   AST_HARD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (|hard_flt) |-> (!out_en && fault_oe && fault_val)); // R8

   AST_FLOAT_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_oe |-> (out_en && !ss_done)); // R10

   AST_SC_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sc_req && out_en) |-> !out_en); // R11
endmodule

bind ss_hiccup_ctrl ss_hiccup_chk #(
   .LVL_W(LVL_W), .CLAMP_LVL(CLAMP_LVL), .NFLT(NFLT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sc_req(sc_req), .hard_flt(hard_flt),
   .err_cmd(err_cmd), .ss_level(ss_level), .ss_done(ss_done),
   .out_en(out_en), .fault_val(fault_val), .fault_oe(fault_oe)
);

// File: tb/ss_hiccup_ctrl_tb.sv
module ss_hiccup_ctrl_tb;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_us = 1'b0;
   logic          oc_flag = 1'b0;
   logic          sc_req = 1'b0;
   logic [2:0]    hard_flt = 3'b000;
   logic [LW-1:0] err_cmd = 8'd100;
   logic [LW-1:0] ss_level;
   logic          ss_done, out_en, fault_val, fault_oe;

   int checks = 0;
   int fails  = 0;
   logic ended = 1'b0;

   always #2 clk = ~clk;

   ss_hiccup_ctrl #(
      .LVL_W(LW), .CLAMP_LVL(200), .SAG_LVL(180), .RESET_LVL(10),
      .CHG_STEP(10), .SLOW_STEP(1), .FAST_STEP(100), .HOLD_TICKS(5), .NFLT(3)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .oc_flag(oc_flag),
      .sc_req(sc_req), .hard_flt(hard_flt), .err_cmd(err_cmd),
      .ss_level(ss_level), .ss_done(ss_done), .out_en(out_en),
      .fault_val(fault_val), .fault_oe(fault_oe)
   );

   typedef struct packed {
      logic       oc;
      logic       sc;
      logic [2:0] hf;
      logic [15:0] nt;
      logic [7:0] lvl;
      logic       done;
      logic       en;
      logic       oe;
      logic       fv;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 3'b000, 16'd10,  8'd100, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3: oc ignored while ramping
      '{1'b0, 1'b0, 3'b000, 16'd1,   8'd110, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2: done once above err
      '{1'b0, 1'b0, 3'b000, 16'd12,  8'd200, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1},  // R1: clamp
      '{1'b1, 1'b0, 3'b000, 16'd3,   8'd198, 1'b1, 1'b1, 1'b1, 1'b0, 4'd4},  // R4: slow sag
      '{1'b0, 1'b0, 3'b000, 16'd4,   8'd194, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5: hold still pending
      '{1'b0, 1'b0, 3'b000, 16'd4,   8'd200, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5: recovered
      '{1'b1, 1'b0, 3'b000, 16'd30,  8'd171, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6: sag shutdown
      '{1'b0, 1'b0, 3'b000, 16'd160, 8'd11,  1'b0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7: still draining
      '{1'b0, 1'b0, 3'b000, 16'd1,   8'd10,  1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7: restart, R10 float
      '{1'b0, 1'b0, 3'b000, 16'd10,  8'd110, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
      '{1'b0, 1'b0, 3'b010, 16'd1,   8'd10,  1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8: fast drain
      '{1'b0, 1'b0, 3'b100, 16'd1,   8'd0,   1'b0, 1'b0, 1'b1, 1'b1, 4'd9},  // R9: fault held, no restart
      '{1'b0, 1'b0, 3'b000, 16'd1,   8'd0,   1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9: restart after clear
      '{1'b0, 1'b0, 3'b000, 16'd12,  8'd120, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
      '{1'b0, 1'b1, 3'b000, 16'd1,   8'd120, 1'b0, 1'b0, 1'b1, 1'b1, 4'd11}, // R11: sc shutdown
      '{1'b0, 1'b0, 3'b000, 16'd110, 8'd10,  1'b0, 1'b1, 1'b0, 1'b0, 4'd11}  // R11: hiccup restart
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_us = 1'b1;
         @(negedge clk);
         tick_us = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic chk_all(input string req, input int lvl, input int done,
                          input int en, input int oe, input int fv);
      chk(req, "ss_level", int'(ss_level), lvl);
      chk(req, "ss_done", int'(ss_done), done);
      chk(req, "out_en", int'(out_en), en);
      chk(req, "fault_oe", int'(fault_oe), oe);
      if (oe != 0) chk(req, "fault_val", int'(fault_val), fv);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R12", 0, 0, 1, 0, 0);  // R12 reset state
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R12", 0, 0, 1, 0, 0);

      for (int v = 0; v < NV; v++) begin
         oc_flag  = VECS[v].oc;
         sc_req   = VECS[v].sc;
         hard_flt = VECS[v].hf;
         run_ticks(int'(VECS[v].nt));
         chk_all($sformatf("R%0d", VECS[v].req), int'(VECS[v].lvl), int'(VECS[v].done),
                 int'(VECS[v].en), int'(VECS[v].oe), int'(VECS[v].fv));
      end
      oc_flag = 1'b0;
      sc_req  = 1'b0;

      // R10 / R8: hard fault during ramp drives fault at once, before any edge
      hard_flt = 3'b001;
      #1;
      chk("R10", "fault_oe during ramp fault", int'(fault_oe), 1);
      chk("R8", "out_en same cycle", int'(out_en), 0);
      chk("R8", "fault_val same cycle", int'(fault_val), 1);
      hard_flt = 3'b000;
      @(negedge clk);
      chk("R10", "fault_oe after clear", int'(fault_oe), 0);
      chk("R1", "level untouched", int'(ss_level), 10);

      // R12: reset from a running state
      run_ticks(10);
      chk("R2", "done before reset", int'(ss_done), 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk_all("R12", 0, 0, 1, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule